// File: doc/BRIEF.md
# DMA Peripheral Request Handshake Controller

This block is the flow-control front end of a general-purpose DMA engine. Every request line can be driven by one of several peripheral sources. A per-line select picks the source. A peripheral raises one of four level-sensitive request kinds:

- burst
- single
- closing burst
- closing single

The controller arbitrates among the lines that are eligible. It takes one request at a time and presents its data beats to a data mover over a valid/ready beat interface.

When the last beat of a request is accepted, the controller answers the peripheral with a one-cycle acknowledge pulse. A terminal-count pulse goes with it when the line's programmed transfer is used up, or when the peripheral marked the request as the end of its packet. Each line keeps its own remaining-transfer counter. That counter is loaded from outside and counts down once per accepted beat. A line is serviced again only after its peripheral has dropped the request that was acknowledged.

Top module: `dma_flow_ctl`

## Requirements
- R1: The request kinds seen by line i come from source `mux_sel_i[2*i+1:2*i]`, taken from input bit `i*N_SRC+sel`. A source option marked absent in `SRC_PRESENT` is treated as never requesting, whatever its inputs do.
- R2: When several lines are eligible in the same cycle, the line with the lowest index is granted first.
- R3: A burst or closing-burst request moves L beats, where L is the line's `burst_len_i` field. A value of 0 is taken as 1. If a burst kind and a single kind are raised together, the burst kind is served.
- R4: A single or closing-single request moves exactly one beat.
- R5: In the cycle after the final beat of a request is accepted, `ack_o` carries a one-cycle pulse on that line's bit, and only on that bit.
- R6: A line's remaining count falls by one per accepted beat. A burst stops early when the count reaches zero. `tc_o` pulses together with the acknowledge when the request leaves the count at zero.
- R7: A closing-burst or closing-single request always pulses `tc_o` with its acknowledge, even when the count is still above zero.
- R8: After an acknowledge, a line is not granted again until all four of its selected request kinds have been low for at least one cycle. A line whose count is zero is never granted.
- R9: While `beat_valid_o` is high and `beat_ready_i` is low, `beat_valid_o` stays high and `beat_line_o` does not change.
- R10: After reset, `beat_valid_o`, `ack_o` and `tc_o` are low and every count is zero. As a result, no line is serviced until its count has been loaded.
- R11: A pulse on `load_en_i[i]` writes `load_cnt_i` into line i's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_burst_i | input | N_LINES*N_SRC | Burst request per line and source |
| src_single_i | input | N_LINES*N_SRC | Single request per line and source |
| src_lburst_i | input | N_LINES*N_SRC | Packet-closing burst request |
| src_lsingle_i | input | N_LINES*N_SRC | Packet-closing single request |
| mux_sel_i | input | N_LINES*SEL_W | Source select per line |
| burst_len_i | input | N_LINES*BL_W | Burst length per line |
| load_en_i | input | N_LINES | Count load strobe per line |
| load_cnt_i | input | CNT_W | Count value to load |
| beat_valid_o | output | 1 | A beat is offered to the data mover |
| beat_ready_i | input | 1 | Data mover accepts the beat |
| beat_line_o | output | IDX_W | Line that owns the current beat |
| ack_o | output | N_LINES | One-cycle acknowledge per line |
| tc_o | output | N_LINES | One-cycle terminal count per line |

## Verification
The bench builds the block with 4 lines, 4 source options, a 3-bit burst length and a 5-bit count. With `SRC_PRESENT` it marks line 3, option 3 as absent.

At that size the bench can sweep every line, every select value and every request kind, including burst and single raised together. The burst lengths and counts vary so that both full bursts and count-truncated bursts occur, the zero-length case included. It computes the expected beat count and terminal-count value arithmetically, runs with and without back-pressure on the ready input, and adds dedicated sequences for priority ordering, re-arming, exhausted counts and the absent source.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
   typedef struct packed {
      logic brst;
      logic sngl;
      logic lbrst;
      logic lsngl;
   } dfc_req_t;

   typedef enum logic {
      DFC_IDLE = 1'b0,
      DFC_MOVE = 1'b1
   } dfc_state_e;
endpackage

// File: rtl/dfc_req_mux.sv
module dfc_req_mux #(
   parameter int N_SRC = 4,
   parameter int SEL_W = 2,
   parameter logic [N_SRC-1:0] PRESENT = '1
) (
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [N_SRC-1:0]  brst_i,
   input  logic [N_SRC-1:0]  sngl_i,
   input  logic [N_SRC-1:0]  lbrst_i,
   input  logic [N_SRC-1:0]  lsngl_i,
   output dfc_pkg::dfc_req_t req_o
);
   dfc_pkg::dfc_req_t opt [N_SRC];

   for (genvar s = 0; s < N_SRC; s++) begin : g_opt
      if (PRESENT[s]) begin : g_wired
         assign opt[s] = '{brst: brst_i[s], sngl: sngl_i[s],
                           lbrst: lbrst_i[s], lsngl: lsngl_i[s]};
      end else begin : g_absent
         assign opt[s] = '0;
      end
   end

   always_comb begin
      req_o = '0;
      for (int s = 0; s < N_SRC; s++) begin
         if (sel_i == SEL_W'(s)) req_o = opt[s];
      end
   end
endmodule

// File: rtl/dfc_prio_pick.sv
module dfc_prio_pick #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     elig_i,
   output logic             vld_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      vld_o = 1'b0;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (elig_i[i]) begin
            vld_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end

   always_comb begin
      if (vld_o) begin
         assert_pick_lowest_R2: assert (elig_i[idx_o] &&
            ((elig_i & ((N'(1) << idx_o) - N'(1))) == '0));
      end
   end
endmodule

// File: rtl/dfc_line_state.sv
module dfc_line_state #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   input  logic             done_i,
   input  logic             req_any_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             armed_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (load_en_i) begin
         cnt_o <= load_val_i;
      end else if (dec_i && cnt_o != '0) begin
         cnt_o <= cnt_o - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_o <= 1'b1;
      end else if (done_i) begin
         armed_o <= 1'b0;
      end else if (!req_any_i) begin
         armed_o <= 1'b1;
      end
   end

   assert_load_takes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      load_en_i |=> cnt_o == $past(load_val_i));
endmodule

// File: rtl/dma_flow_ctl.sv
module dma_flow_ctl #(
   parameter int N_LINES = 16,
   parameter int N_SRC   = 4,
   parameter int BL_W    = 4,
   parameter int CNT_W   = 12,
   parameter logic [N_LINES*N_SRC-1:0] SRC_PRESENT = '1,
   localparam int SEL_W = $clog2(N_SRC),
   localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_LINES*N_SRC-1:0]   src_burst_i,
   input  logic [N_LINES*N_SRC-1:0]   src_single_i,
   input  logic [N_LINES*N_SRC-1:0]   src_lburst_i,
   input  logic [N_LINES*N_SRC-1:0]   src_lsingle_i,
   input  logic [N_LINES*SEL_W-1:0]   mux_sel_i,
   input  logic [N_LINES*BL_W-1:0]    burst_len_i,
   input  logic [N_LINES-1:0]         load_en_i,
   input  logic [CNT_W-1:0]           load_cnt_i,
   output logic                       beat_valid_o,
   input  logic                       beat_ready_i,
   output logic [IDX_W-1:0]           beat_line_o,
   output logic [N_LINES-1:0]         ack_o,
   output logic [N_LINES-1:0]         tc_o
);
   import dfc_pkg::*;

   if (N_SRC < 2 || (N_SRC & (N_SRC - 1)) != 0) begin : g_bad_src
      $error("N_SRC must be a power of two, at least 2");
   end
   if (N_LINES < 1 || BL_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("N_LINES, BL_W and CNT_W must be at least 1");
   end

   dfc_req_t         req   [N_LINES];
   logic [CNT_W-1:0] cnt   [N_LINES];
   logic [N_LINES-1:0] armed, elig;

   dfc_state_e       state_q;
   logic [IDX_W-1:0] cur_q;
   logic [BL_W-1:0]  left_q;
   logic             last_q;
   logic             pick_vld;
   logic [IDX_W-1:0] pick_idx;
   logic             hs, fin;
   logic [CNT_W-1:0] cur_cnt;

   assign hs      = (state_q == DFC_MOVE) && beat_ready_i;
   assign cur_cnt = cnt[cur_q];
   assign fin     = hs && (left_q == BL_W'(1) || cur_cnt <= CNT_W'(1));

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      dfc_req_mux #(
         .N_SRC  (N_SRC),
         .SEL_W  (SEL_W),
         .PRESENT(SRC_PRESENT[i*N_SRC +: N_SRC])
      ) i_mux (
         .sel_i  (mux_sel_i[i*SEL_W +: SEL_W]),
         .brst_i (src_burst_i[i*N_SRC +: N_SRC]),
         .sngl_i (src_single_i[i*N_SRC +: N_SRC]),
         .lbrst_i(src_lburst_i[i*N_SRC +: N_SRC]),
         .lsngl_i(src_lsingle_i[i*N_SRC +: N_SRC]),
         .req_o  (req[i])
      );

      dfc_line_state #(.CNT_W(CNT_W)) i_state (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_en_i (load_en_i[i]),
         .load_val_i(load_cnt_i),
         .dec_i     (hs && cur_q == IDX_W'(i)),
         .done_i    (fin && cur_q == IDX_W'(i)),
         .req_any_i (|req[i]),
         .cnt_o     (cnt[i]),
         .armed_o   (armed[i])
      );

      assign elig[i] = armed[i] && (|req[i]) && (cnt[i] != '0);
   end

   dfc_prio_pick #(.N(N_LINES), .IDX_W(IDX_W)) i_pick (
      .elig_i(elig),
      .vld_o (pick_vld),
      .idx_o (pick_idx)
   );

   dfc_req_t         g_req;
   logic             g_burst;
   logic [BL_W-1:0]  g_len;
   assign g_req   = req[pick_idx];
   assign g_burst = g_req.brst || g_req.lbrst;
   assign g_len   = burst_len_i[pick_idx*BL_W +: BL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DFC_IDLE;
         cur_q   <= '0;
         left_q  <= '0;
         last_q  <= 1'b0;
         ack_o   <= '0;
         tc_o    <= '0;
      end else begin
         ack_o <= '0;
         tc_o  <= '0;
         if (state_q == DFC_IDLE) begin
            if (pick_vld) begin
               state_q <= DFC_MOVE;
               cur_q   <= pick_idx;
               if (g_burst) begin
                  left_q <= (g_len == '0) ? BL_W'(1) : g_len;
                  last_q <= g_req.lbrst;
               end else begin
                  left_q <= BL_W'(1);
                  last_q <= g_req.lsngl;
               end
            end
         end else if (hs) begin
            left_q <= left_q - BL_W'(1);
            if (fin) begin
               state_q       <= DFC_IDLE;
               ack_o[cur_q]  <= 1'b1;
               tc_o[cur_q]   <= last_q || (cur_cnt <= CNT_W'(1));
            end
         end
      end
   end

   assign beat_valid_o = (state_q == DFC_MOVE);
   assign beat_line_o  = cur_q;

   assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_o));
   assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o != '0) |=> (ack_o == '0));
   assert_ack_after_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o != '0) |-> $past(beat_valid_o && beat_ready_i));
   assert_tc_with_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_o & ~ack_o) == '0);
   assert_beat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid_o && !beat_ready_i) |=> (beat_valid_o && $stable(beat_line_o)));
endmodule

// File: tb/test_dma_flow_ctl.sv
module test_dma_flow_ctl;
   localparam int NL  = 4;
   localparam int NS  = 4;
   localparam int SW  = 2;
   localparam int BLW = 3;
   localparam int CW  = 5;
   localparam int IW  = 2;
   localparam logic [NL*NS-1:0] PRES = 16'h7FFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NL*NS-1:0] sb = '0, ss = '0, slb = '0, sls = '0;
   logic [NL*SW-1:0] sel = '0;
   logic [NL*BLW-1:0] blen = '0;
   logic [NL-1:0] lden = '0;
   logic [CW-1:0] ldcnt = '0;
   logic ready = 1'b1;
   logic bvalid;
   logic [IW-1:0] bline;
   logic [NL-1:0] ack, tc;

   int total = 0, bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   dma_flow_ctl #(.N_LINES(NL), .N_SRC(NS), .BL_W(BLW), .CNT_W(CW),
                  .SRC_PRESENT(PRES)) i_dma_flow_ctl (
      .clk(clk), .rst_n(rst_n),
      .src_burst_i(sb), .src_single_i(ss),
      .src_lburst_i(slb), .src_lsingle_i(sls),
      .mux_sel_i(sel), .burst_len_i(blen),
      .load_en_i(lden), .load_cnt_i(ldcnt),
      .beat_valid_o(bvalid), .beat_ready_i(ready),
      .beat_line_o(bline), .ack_o(ack), .tc_o(tc));

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load(int ln, int c);
      @(negedge clk);
      lden = '0; lden[ln] = 1'b1; ldcnt = CW'(c);
      @(negedge clk);
      lden = '0;
   endtask

   // kind: 0 burst, 1 single, 2 closing burst, 3 closing single, 4 burst+single
   task automatic raise(int ln, int sl, int kd);
      int b = ln * NS + sl;
      if (kd == 0 || kd == 4) sb[b] = 1'b1;
      if (kd == 1 || kd == 4) ss[b] = 1'b1;
      if (kd == 2) slb[b] = 1'b1;
      if (kd == 3) sls[b] = 1'b1;
   endtask

   task automatic drop_all();
      sb = '0; ss = '0; slb = '0; sls = '0;
   endtask

   // serve a raised request; returns when ack seen or timeout
   task automatic serve(int ln, int exp_beats, bit exp_tc, bit stall, string tag);
      int beats = 0;
      int cyc = 0;
      bit got = 0;
      logic [NL-1:0] a = '0, t = '0;
      while (cyc < 100 && !got) begin
         @(negedge clk);
         ready = stall ? ((cyc % 3) != 1) : 1'b1;
         #1;
         if (ack != '0) begin
            got = 1; a = ack; t = tc;
         end else if (bvalid) begin
            if (bline != IW'(ln)) chk(0, "R9 beat line", int'(bline), ln);
            if (ready) beats++;
         end
         cyc++;
      end
      chk(beats == exp_beats, {tag, " beats"}, beats, exp_beats);
      chk(a == (NL'(1) << ln), "R5 ack line", int'(a), 1 << ln);
      chk(t[ln] == exp_tc, exp_tc ? "R6/R7 tc set" : "R6 tc clear", int'(t[ln]), int'(exp_tc));
      ready = 1'b1;
   endtask

   task automatic expect_idle(int n, string tag);
      int seen = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk); #1;
         if (bvalid || ack != '0) seen++;
      end
      chk(seen == 0, tag, seen, 0);
   endtask

   initial begin : watchdog
      int c = 0;
      while (!done) begin
         @(posedge clk);
         c++;
         if (c > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", c, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      #1;
      chk(!bvalid && ack == '0 && tc == '0, "R10 reset outputs",
          int'({bvalid, ack, tc}), 0);
      rst_n = 1'b1;
      // R10: counts start at zero so an unloaded line is never served
      @(negedge clk);
      raise(0, 0, 1);
      expect_idle(8, "R10 unloaded line idle");
      drop_all();
      @(negedge clk);

      // full sweep: R1, R3, R4, R6, R7, R8, R11
      for (int ln = 0; ln < NL; ln++)
         for (int sl = 0; sl < NS; sl++)
            for (int kd = 0; kd < 5; kd++) begin
               int bl = (ln + 3 * sl + kd) % 8;
               int ct = ((ln * 5 + sl * 3 + kd * 2) % 9) + 1;
               bit isb = (kd == 0 || kd == 2 || kd == 4);
               int want = isb ? ((bl == 0) ? 1 : bl) : 1;
               int eb;
               bit et;
               if (ln == 3 && sl == 3) continue;
               if (want > ct) want = ct;
               eb = want;
               et = (ct - eb == 0) || kd == 2 || kd == 3;
               sel = '0; sel[ln*SW +: SW] = SW'(sl);
               blen = '0; blen[ln*BLW +: BLW] = BLW'(bl);
               load(ln, ct);
               raise(ln, sl, kd);
               serve(ln, eb, et, ((ln + sl + kd) % 2) == 1,
                     isb ? "R3 burst" : "R4 single");
               expect_idle(4, "R8 held request not regranted");
               drop_all();
               @(negedge clk);
            end

      // R1: absent source option never requests
      sel = '0; sel[3*SW +: SW] = 2'd3;
      load(3, 4);
      raise(3, 3, 0);
      expect_idle(10, "R1 absent option");
      drop_all();
      // R1: request on a non-selected source is not seen
      sel = '0; sel[0 +: SW] = 2'd1;
      load(0, 4);
      raise(0, 2, 1);
      expect_idle(10, "R1 unselected source");
      drop_all();
      @(negedge clk);

      // R6/R8: count carries over, truncates, then blocks
      sel = '0; blen = '0; blen[2*BLW +: BLW] = 3'd3;
      load(2, 5);
      raise(2, 0, 0); serve(2, 3, 0, 0, "R6 first burst");
      drop_all(); @(negedge clk);
      raise(2, 0, 0); serve(2, 2, 1, 1, "R6 truncated burst");
      drop_all(); @(negedge clk);
      raise(2, 0, 0);
      expect_idle(10, "R8 exhausted count");
      drop_all(); @(negedge clk);

      // R2: lines 3,1,2 request together; expect order 1,2,3
      begin
         int order [3];
         int n = 0;
         sel = '0;
         load(1, 3); load(2, 3); load(3, 3);
         @(negedge clk);
         raise(3, 0, 1); raise(1, 0, 1); raise(2, 0, 1);
         for (int k = 0; k < 40 && n < 3; k++) begin
            @(negedge clk); #1;
            for (int j = 0; j < NL; j++)
               if (ack[j]) begin order[n] = j; n++; end
         end
         chk(n == 3, "R2 ack count", n, 3);
         for (int k = 0; k < 3; k++)
            chk(order[k] == k + 1, "R2 priority order", order[k], k + 1);
         drop_all();
      end

      repeat (3) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule